// File: doc/BRIEF.md
# Shared-Pin Parallel I/O Controller

This block arbitrates a bank of up to 32 general-purpose lines. Each line is driven either by the controller or by a peripheral signal that shares the line. A small memory-mapped register bus sets pin ownership, output direction and output level. Every one of these settings is changed through a pair of write-only addresses, one that sets bits and one that clears them. Matching read-only addresses return the stored state, the live pin level and the pending change-of-input events.

A fixed set of lines is reserved as pure general-purpose pins. These lines are always owned by the controller, and ownership writes do not touch them. While the controller owns a line, the peripheral input for that line is held low. The pad inputs pass through a two-flop synchronizer before they reach the pin-level register and the change detector. Change events are gated by a per-pin mask and raise a single interrupt line.

Top module: `mpio_ctrl`

## Requirements
- R1: After reset, the ownership status (0x08) reads 0xFFFFFFFF. The output-enable status (0x18), output-data status (0x38) and mask status (0x48) read 0. pad_oe is 0 and irq is 0.
- R2: A write to 0x00 gives the pins whose data bits are 1 to the controller. A write to 0x04 gives those pins to the peripheral. Bits written as 0 are left unchanged. 0x08 reads the ownership back, with 1 meaning controller-owned.
- R3: Bit positions 16, 17, 18, 19, 23 and 24 are reserved general-purpose pins. Writes to 0x00 and 0x04 do not change them, their ownership bit always reads 1, and their per_in bit is always 0.
- R4: When the controller owns a pin, per_in is 0 for that pin. When the peripheral owns a pin, pad_out follows per_out, pad_oe follows per_oe and per_in follows pad_in.
- R5: A write to 0x10 sets output-enable bits and a write to 0x14 clears them. 0x18 reads them back. pad_oe follows a pin's output-enable bit only while the controller owns that pin.
- R6: A write to 0x30 sets output-data bits and a write to 0x34 clears them. 0x38 reads them back. pad_out follows a pin's data bit while the controller owns that pin.
- R7: 0x3C returns the pad_in level of every pin, whoever owns it, after two synchronizer flops.
- R8: Writes to the status addresses 0x08, 0x18, 0x38, 0x3C, 0x48 and 0x4C change nothing. Reads of the write-only addresses and of unmapped addresses return 0.
- R9: A write to 0x40 sets interrupt-mask bits and a write to 0x44 clears them. 0x48 reads them back.
- R10: A pin's bit in 0x4C is set when its synchronized level changes. A read of 0x4C returns the pending bits and clears them. A change seen in the same cycle as the read stays pending.
- R11: irq is 1 exactly when some pin has a pending change bit and its mask bit set.
- R12: Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| per_out | input | 32 | Peripheral output level per pin |
| per_oe | input | 32 | Peripheral output enable per pin |
| per_in | output | 32 | Input seen by the peripheral |
| pad_out | output | 32 | Level driven toward the pad |
| pad_oe | output | 32 | Pad driver enable |
| pad_in | input | 32 | Level sampled at the pad |
| irq | output | 1 | Masked change-of-input interrupt |

## Verification
A wrong ownership bit shows at once on the pins. pad_out, pad_oe and per_in switch between the controller and peripheral sources from the cycle after the write, so the bench compares all three against a model after every configuration write. A corrupted direction or data bit stays hidden on pins the peripheral owns. It shows only once the controller takes the pin back, or on the next readback of the status address, one cycle after the read strobe. A stuck or missed change event shows on irq two to three cycles after a pad edge, and it also shows in the clear-on-read value of the event register.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
   localparam int unsigned OFS_W = 8;
   localparam logic [OFS_W-1:0] OFS_OWN_SET  = 8'h00;
   localparam logic [OFS_W-1:0] OFS_OWN_CLR  = 8'h04;
   localparam logic [OFS_W-1:0] OFS_OWN_STAT = 8'h08;
   localparam logic [OFS_W-1:0] OFS_OE_SET   = 8'h10;
   localparam logic [OFS_W-1:0] OFS_OE_CLR   = 8'h14;
   localparam logic [OFS_W-1:0] OFS_OE_STAT  = 8'h18;
   localparam logic [OFS_W-1:0] OFS_DAT_SET  = 8'h30;
   localparam logic [OFS_W-1:0] OFS_DAT_CLR  = 8'h34;
   localparam logic [OFS_W-1:0] OFS_DAT_STAT = 8'h38;
   localparam logic [OFS_W-1:0] OFS_PIN_STAT = 8'h3C;
   localparam logic [OFS_W-1:0] OFS_MSK_SET  = 8'h40;
   localparam logic [OFS_W-1:0] OFS_MSK_CLR  = 8'h44;
   localparam logic [OFS_W-1:0] OFS_MSK_STAT = 8'h48;
   localparam logic [OFS_W-1:0] OFS_EVT_STAT = 8'h4C;

   typedef struct packed {
      logic set;
      logic clr;
   } setclr_we_t;
endpackage

// File: rtl/mpio_setclr.sv
module mpio_setclr #(
   parameter int unsigned W          = 32,
   parameter logic [W-1:0] RST_VAL   = '0,
   parameter logic [W-1:0] FORCE_ONE = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  mpio_pkg::setclr_we_t  we,
   input  logic [W-1:0]          wdata,
   output logic [W-1:0]          q
);
   logic [W-1:0] q_r;
   logic [W-1:0] q_nxt;

   always_comb begin
      q_nxt = q_r;
      if (we.set) q_nxt = q_nxt | wdata;
      if (we.clr) q_nxt = q_nxt & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RST_VAL;
      else        q_r <= q_nxt;
   end

   generate
      if (FORCE_ONE == '0) begin : g_plain
         assign q = q_r;
      end else begin : g_forced
         assign q = q_r | FORCE_ONE;
      end
   endgenerate

   // R2 R5 R6 R9: set bits appear one cycle after a set write
   assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we.set && !we.clr) |=> ((q & $past(wdata)) == $past(wdata)));
   // R2: bits written as zero keep their value
   assert_zero_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we.set || we.clr) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
endmodule

// File: rtl/mpio_sync.sv
module mpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mpio_chg_irq.sv
module mpio_chg_irq #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic         rd_clr,
   input  logic [W-1:0] mask,
   output logic [W-1:0] evt,
   output logic         irq
);
   logic [W-1:0] lvl_d;
   logic [W-1:0] chg;

   assign chg = lvl ^ lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d <= '0;
         evt   <= '0;
      end else begin
         lvl_d <= lvl;
         evt   <= (rd_clr ? '0 : evt) | chg;
      end
   end

   assign irq = |(evt & mask);

   // R10: after a clearing read only changes seen in that cycle remain
   assert_clear_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> ((evt & ~$past(chg)) == '0));
   // R10: a detected change is never lost
   assert_change_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |=> ((evt & $past(chg)) == $past(chg)));
endmodule

// File: rtl/mpio_ctrl.sv
module mpio_ctrl #(
   parameter int unsigned NPINS    = 32,
   parameter int unsigned BUS_W    = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned SYNC_LEN = 2,
   parameter logic [NPINS-1:0] GP_ONLY = 32'h018F_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  per_out,
   input  logic [NPINS-1:0]  per_oe,
   output logic [NPINS-1:0]  per_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  pad_in,
   output logic              irq
);
   import mpio_pkg::*;

   generate
      if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
         $error("mpio_ctrl: NPINS must be in 1..BUS_W");
      end
      if (ADDR_W < OFS_W) begin : g_bad_addr
         $error("mpio_ctrl: ADDR_W too narrow for the register map");
      end
   endgenerate

   localparam logic [NPINS-1:0] OWN_RST = '1;

   logic              wr_stb, rd_stb;
   logic [NPINS-1:0]  wd;
   setclr_we_t        we_own, we_oe, we_dat, we_msk;
   logic [NPINS-1:0]  own, oe, dat, msk, lvl, evt;
   logic              evt_rd;

   assign wr_stb = bus_sel & bus_wr;
   assign rd_stb = bus_sel & ~bus_wr;
   assign wd     = bus_wdata[NPINS-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFS_W-1:0] o);
      return a == ADDR_W'(o);
   endfunction

   always_comb begin
      we_own.set = wr_stb & hit(bus_addr, OFS_OWN_SET);
      we_own.clr = wr_stb & hit(bus_addr, OFS_OWN_CLR);
      we_oe.set  = wr_stb & hit(bus_addr, OFS_OE_SET);
      we_oe.clr  = wr_stb & hit(bus_addr, OFS_OE_CLR);
      we_dat.set = wr_stb & hit(bus_addr, OFS_DAT_SET);
      we_dat.clr = wr_stb & hit(bus_addr, OFS_DAT_CLR);
      we_msk.set = wr_stb & hit(bus_addr, OFS_MSK_SET);
      we_msk.clr = wr_stb & hit(bus_addr, OFS_MSK_CLR);
   end

   assign evt_rd = rd_stb & hit(bus_addr, OFS_EVT_STAT);

   mpio_setclr #(.W(NPINS), .RST_VAL(OWN_RST), .FORCE_ONE(GP_ONLY)) u_own (
      .clk(clk), .rst_n(rst_n), .we(we_own), .wdata(wd), .q(own));
   mpio_setclr #(.W(NPINS), .RST_VAL('0), .FORCE_ONE('0)) u_oe (
      .clk(clk), .rst_n(rst_n), .we(we_oe), .wdata(wd), .q(oe));
   mpio_setclr #(.W(NPINS), .RST_VAL('0), .FORCE_ONE('0)) u_dat (
      .clk(clk), .rst_n(rst_n), .we(we_dat), .wdata(wd), .q(dat));
   mpio_setclr #(.W(NPINS), .RST_VAL('0), .FORCE_ONE('0)) u_msk (
      .clk(clk), .rst_n(rst_n), .we(we_msk), .wdata(wd), .q(msk));

   mpio_sync #(.W(NPINS), .STAGES(SYNC_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl));

   mpio_chg_irq #(.W(NPINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rd_clr(evt_rd),
      .mask(msk), .evt(evt), .irq(irq));

   // pin steering
   assign pad_out = (own & dat) | (~own & per_out);
   assign pad_oe  = (own & oe)  | (~own & per_oe);
   assign per_in  = ~own & pad_in;

   // registered read port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_stb) begin
         bus_rdata <= '0;
         if      (hit(bus_addr, OFS_OWN_STAT)) bus_rdata <= BUS_W'(own);
         else if (hit(bus_addr, OFS_OE_STAT))  bus_rdata <= BUS_W'(oe);
         else if (hit(bus_addr, OFS_DAT_STAT)) bus_rdata <= BUS_W'(dat);
         else if (hit(bus_addr, OFS_PIN_STAT)) bus_rdata <= BUS_W'(lvl);
         else if (hit(bus_addr, OFS_MSK_STAT)) bus_rdata <= BUS_W'(msk);
         else if (hit(bus_addr, OFS_EVT_STAT)) bus_rdata <= BUS_W'(evt);
      end
   end

   // R3: reserved general-purpose pins never pass the pad to the peripheral
   assert_gp_per_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((per_in & GP_ONLY) == '0));
   // R8: write-only addresses read back as zero
   assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && (hit(bus_addr, OFS_OWN_SET) || hit(bus_addr, OFS_DAT_CLR)))
      |=> (bus_rdata == '0));
   // R12: read data holds while no read is issued
   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(bus_rdata));
endmodule

// File: tb/sim_mpio_ctrl.sv
module sim_mpio_ctrl;
   localparam logic [31:0] GP = 32'h018F_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [31:0] per_out = '0, per_oe = '0, per_in;
   logic [31:0] pad_out, pad_oe, pad_in = '0;
   logic        irq;

   int vectors = 0, errors = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   // bench model of the stored state
   logic [31:0] m_own = 32'hFFFF_FFFF, m_oe = '0, m_dat = '0;

   always #10 clk = ~clk;   // 50 MHz

   mpio_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .per_out(per_out), .per_oe(per_oe), .per_in(per_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in), .irq(irq));

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   // driver: issues the read and queues the expected value
   task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // monitor: read data is due one edge after the strobe (R12)
   initial begin
      forever begin
         @(posedge clk);
         if (bus_sel && !bus_wr) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               cmp("R12 unexpected read", bus_rdata, 32'h0);
            end else begin
               cmp(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
         end
      end
   end

   task automatic check_pins(input string tag);
      cmp({tag, " pad_out"}, pad_out, (m_own & m_dat) | (~m_own & per_out));
      cmp({tag, " pad_oe"},  pad_oe,  (m_own & m_oe)  | (~m_own & per_oe));
      cmp({tag, " per_in"},  per_in,  ~m_own & pad_in);
   endtask

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #4000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      wait_clks(3);
      rst_n = 1'b1;
      wait_clks(1);

      // R1 reset state
      cmp("R1 pad_oe", pad_oe, 32'h0);
      cmp("R1 irq", {31'h0, irq}, 32'h0);
      bus_read(8'h08, 32'hFFFF_FFFF, "R1 own status");
      bus_read(8'h18, 32'h0, "R1 oe status");
      bus_read(8'h38, 32'h0, "R1 data status");
      bus_read(8'h48, 32'h0, "R1 mask status");

      // R2 R3: hand all to the peripheral, reserved pins stay owned
      bus_write(8'h04, 32'hFFFF_FFFF);
      m_own = GP;
      bus_read(8'h08, GP, "R3 reserved pins still owned");
      per_out = 32'hA5A5_A5A5; per_oe = 32'h0F0F_0F0F; pad_in = 32'h3C3C_3C3C;
      wait_clks(1);
      check_pins("R4 peripheral path");
      cmp("R3 per_in reserved low", per_in & GP, 32'h0);

      // R2: take back low byte, zero bits unchanged
      bus_write(8'h00, 32'h0000_00FF);
      m_own = GP | 32'h0000_00FF;
      bus_read(8'h08, m_own, "R2 partial enable");
      check_pins("R4 mixed ownership");

      // R5 direction
      bus_write(8'h10, 32'h0000_F0F0);
      bus_write(8'h14, 32'h0000_3000);
      m_oe = 32'h0000_C0F0;
      bus_read(8'h18, m_oe, "R5 oe status");
      check_pins("R5 oe only where owned");

      // R6 data
      bus_write(8'h30, 32'hFFFF_0000);
      bus_write(8'h34, 32'h0F00_0000);
      m_dat = 32'hF0FF_0000;
      bus_read(8'h38, m_dat, "R6 data status");
      check_pins("R6 data on owned pins");

      // R8: status writes ignored, write-only and unmapped reads zero
      bus_write(8'h08, 32'h0);
      bus_write(8'h38, 32'h0);
      bus_write(8'h18, 32'hFFFF_FFFF);
      bus_read(8'h08, m_own, "R8 own status unchanged");
      bus_read(8'h38, m_dat, "R8 data status unchanged");
      bus_read(8'h18, m_oe, "R8 oe status unchanged");
      bus_read(8'h00, 32'h0, "R8 write-only read zero");
      bus_read(8'h34, 32'h0, "R8 clear-data read zero");
      bus_read(8'h44, 32'h0, "R8 mask-clear read zero");
      bus_read(8'h7C, 32'h0, "R8 unmapped read zero");
      check_pins("R8 pins unchanged");

      // R10 events from the 0 -> 3C3C3C3C pad change, clear on read
      bus_read(8'h4C, 32'h3C3C_3C3C, "R10 pending events");
      bus_read(8'h4C, 32'h0, "R10 cleared after read");

      // R7 pin level regardless of owner
      pad_in = 32'h1234_5678;
      wait_clks(3);
      bus_read(8'h3C, 32'h1234_5678, "R7 pin level");
      check_pins("R4 per_in follows pad");

      // R9 R11 mask and interrupt
      bus_write(8'h40, 32'h0000_0001);
      bus_read(8'h48, 32'h0000_0001, "R9 mask status");
      cmp("R11 irq masked out", {31'h0, irq}, 32'h0);
      bus_read(8'h4C, 32'h3C3C_3C3C ^ 32'h1234_5678, "R10 new events");
      pad_in = 32'h1234_5679;
      wait_clks(4);
      cmp("R11 irq on masked-in change", {31'h0, irq}, 32'h1);
      bus_write(8'h44, 32'h0000_0001);
      cmp("R11 irq after mask clear", {31'h0, irq}, 32'h0);
      bus_read(8'h48, 32'h0, "R9 mask cleared");
      bus_read(8'h4C, 32'h0000_0001, "R10 bit0 pending");
      bus_write(8'h40, 32'h0000_0001);
      cmp("R11 irq stays low after clear", {31'h0, irq}, 32'h0);

      wait_clks(3);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule